// File: doc/BRIEF.md
# Punctured Convolutional Encoder with Serial Output

This block takes one data bit per accepted strobe and passes it through a rate-1/2 convolutional encoder. The constraint length and both generator polynomials are parameters. The two code bits of each input are collected into a block of n positions. Two n-bit keep masks then remove some of the code bits, so that m of the 2n bits remain and the code rate becomes n/m. The remaining bits leave one per clock on a single serial line, and a valid flag marks each one.

More bits leave than arrive. For that reason the block drops its ready output for m-n cycles after every completed input block, and that stall holds back the upstream strobe. A completed block is first parked in a holding register. It is streamed out when the following block completes, so the output runs exactly one block behind the input, and the first block after reset is all zeros. A first-data input restarts the puncture position at the current bit. A ready-for-first output shows when a restart lines up with a block boundary. A clock enable freezes the whole block, and a synchronous clear returns it to its idle state.

Top module: `punct_conv_enc_serial`

## Requirements
- R1: Each accepted bit forms a window in which bit 0 is the current input and bit i is the input accepted i strobes earlier (zero after reset). Code bit 0 is the XOR of the window bits selected by GEN0, and code bit 1 is the XOR of the bits selected by GEN1.
- R2: The position j (0..PLEN-1) of a bit within its block selects bit j of PAT0 for code bit 0 and bit j of PAT1 for code bit 1. A 1 keeps the bit. Kept bits are sent in order of position, and within a position code bit 0 goes before code bit 1.
- R3: After the accept that completes a block, in_rdy is low for exactly KEPT-PLEN cycles, where KEPT is the total number of ones in PAT0 and PAT1. A strobe presented while in_rdy is low is not sampled.
- R4: Every completed block puts out KEPT bits on consecutive cycles with out_vld high. Input block k appears in output block k+1, and the first output block after reset is all zeros.
- R5: An accepted strobe with in_first high restarts the position count at 0 for the current bit, provided in_first was low on the previous accepted strobe. Bits already collected for an unfinished block are discarded.
- R6: first_ok is high when the position count is 0 and in_rdy is high. It is low in the cycle after a restart.
- R7: When in_first stays high over several accepted strobes, only the first of them restarts the count.
- R8: While en is low, no input is sampled and all state and outputs hold their values.
- R9: srst clears the code history, the position count, the collected bits and the holding register. While srst is applied and afterwards, in_rdy and first_ok are high and out_vld is low, and no bit is sampled while srst is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous clear, active high |
| en | input | 1 | Clock enable; low freezes the block |
| in_vld | input | 1 | New-bit strobe |
| in_bit | input | 1 | Data bit to encode |
| in_first | input | 1 | Restart the puncture position at this bit |
| in_rdy | output | 1 | Block can take a bit this cycle |
| first_ok | output | 1 | A restart now falls on a block boundary |
| out_bit | output | 1 | Serial punctured code bit |
| out_vld | output | 1 | out_bit is valid |

## Verification
The embedded properties check the following on every cycle:
- the stall that follows each completed block, and that a strobe offered during the stall leaves the position count alone;
- that a new block is never loaded while the serializer still holds more than one bit;
- the freeze while en is low, the drop of first_ok after a restart, and the idle state after srst.

The bench scenarios cover what a property cannot express:
- the bit-exact code values and the order in which kept bits leave;
- the one-block delay and the leading block of zeros;
- realignment after a mid-block restart and after a first-data input held high;
- that stall-time data and clear-time data never enter the stream.

// File: rtl/pce_pkg.sv
package pce_pkg;
  function automatic int count_ones(input logic [31:0] v);
    int s;
    s = 0;
    for (int i = 0; i < 32; i++) s += int'(v[i]);
    return s;
  endfunction
endpackage

// File: rtl/pce_taps.sv
module pce_taps #(
  parameter int CLEN = 7,
  parameter logic [CLEN-1:0] GEN0 = 7'b1011011,
  parameter logic [CLEN-1:0] GEN1 = 7'b1111001
) (
  input  logic clk,
  input  logic srst,
  input  logic step,
  input  logic bit_i,
  output logic enc0,
  output logic enc1
);
  localparam int HW = CLEN - 1;

  logic [HW-1:0]   hist;
  logic [CLEN-1:0] window;

  assign window = {hist, bit_i};
  assign enc0   = ^(window & GEN0);
  assign enc1   = ^(window & GEN1);

  always_ff @(posedge clk) begin
    if (srst)      hist <= '0;
    else if (step) hist <= window[HW-1:0];
  end

  // R9
  hist_clear_chk: assert property (@(posedge clk) srst |=> (hist == '0));
endmodule

// File: rtl/pce_collect.sv
module pce_collect #(
  parameter int PLEN = 3,
  parameter logic [PLEN-1:0] PAT0 = 3'b101,
  parameter logic [PLEN-1:0] PAT1 = 3'b011,
  parameter int KEPT = 4
) (
  input  logic            clk,
  input  logic            srst,
  input  logic            en,
  input  logic            req,
  input  logic            first,
  input  logic            enc0,
  input  logic            enc1,
  output logic            accept,
  output logic            ready,
  output logic            first_ok,
  output logic            blk_done,
  output logic [KEPT-1:0] blk_bits
);
  localparam int GAP = KEPT - PLEN;
  localparam int PW  = (PLEN > 1) ? $clog2(PLEN) : 1;
  localparam int GW  = $clog2(PLEN + 1);

  logic [PW-1:0]   pos, slot;
  logic [GW-1:0]   gap_cnt;
  logic            first_prev, restart;
  logic [PLEN-1:0] col0, col1, col0_n, col1_n;
  logic [KEPT-1:0] hold;

  function automatic logic [KEPT-1:0] squeeze(input logic [PLEN-1:0] a,
                                              input logic [PLEN-1:0] b);
    logic [KEPT-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int j = 0; j < PLEN; j++) begin
      if (PAT0[j]) begin
        if (k < KEPT) r[k] = a[j];
        k++;
      end
      if (PAT1[j]) begin
        if (k < KEPT) r[k] = b[j];
        k++;
      end
    end
    return r;
  endfunction

  assign ready    = (gap_cnt == '0);
  assign first_ok = ready && (pos == '0);
  assign accept   = en && req && ready && !srst;
  assign restart  = accept && first && !first_prev;
  assign slot     = restart ? '0 : pos;
  assign blk_done = accept && (slot == PW'(PLEN - 1));
  assign blk_bits = hold;

  always_comb begin
    col0_n = col0;
    col1_n = col1;
    col0_n[slot] = enc0;
    col1_n[slot] = enc1;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      pos        <= '0;
      gap_cnt    <= '0;
      first_prev <= 1'b0;
      col0       <= '0;
      col1       <= '0;
      hold       <= '0;
    end else if (en) begin
      if (accept) begin
        col0       <= col0_n;
        col1       <= col1_n;
        first_prev <= first;
        pos        <= blk_done ? '0 : slot + 1'b1;
      end
      if (blk_done)
        hold <= squeeze(col0_n, col1_n);
      if (blk_done)
        gap_cnt <= GW'(GAP);
      else if (gap_cnt != '0)
        gap_cnt <= gap_cnt - 1'b1;
    end
  end

  // R3
  stall_after_block_chk: assert property (@(posedge clk) disable iff (srst)
    blk_done |=> !ready);
  // R3
  stall_ignores_req_chk: assert property (@(posedge clk) disable iff (srst)
    (en && req && !ready) |=> (pos == $past(pos)));
  // R6
  first_drop_chk: assert property (@(posedge clk) disable iff (srst)
    restart |=> !first_ok);
  // R5
  restart_pos_chk: assert property (@(posedge clk) disable iff (srst)
    restart |=> (pos == PW'(1)));
endmodule

// File: rtl/pce_serial.sv
module pce_serial #(
  parameter int KEPT = 4
) (
  input  logic            clk,
  input  logic            srst,
  input  logic            en,
  input  logic            load,
  input  logic [KEPT-1:0] blk,
  output logic            out_bit,
  output logic            out_vld
);
  localparam int CW = $clog2(KEPT + 1);

  logic [KEPT-1:0] sh;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (srst) begin
      sh      <= '0;
      cnt     <= '0;
      out_bit <= 1'b0;
      out_vld <= 1'b0;
    end else if (en) begin
      out_vld <= (cnt != '0);
      out_bit <= (cnt != '0) ? sh[0] : 1'b0;
      if (load) begin
        sh  <= blk;
        cnt <= CW'(KEPT);
      end else if (cnt != '0) begin
        sh  <= sh >> 1;
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R4
  run_continues_chk: assert property (@(posedge clk) disable iff (srst)
    (en && cnt != '0) |=> out_vld);
  // R4
  no_overrun_chk: assert property (@(posedge clk) disable iff (srst)
    load |-> (cnt <= CW'(1)));
  // R8
  freeze_out_chk: assert property (@(posedge clk) disable iff (srst)
    !en |=> ($stable(out_bit) && $stable(out_vld)));
endmodule

// File: rtl/punct_conv_enc_serial.sv
module punct_conv_enc_serial #(
  parameter int CLEN = 7,
  parameter logic [CLEN-1:0] GEN0 = 7'b1011011,
  parameter logic [CLEN-1:0] GEN1 = 7'b1111001,
  parameter int PLEN = 3,
  parameter logic [PLEN-1:0] PAT0 = 3'b101,
  parameter logic [PLEN-1:0] PAT1 = 3'b011
) (
  input  logic clk,
  input  logic srst,
  input  logic en,
  input  logic in_vld,
  input  logic in_bit,
  input  logic in_first,
  output logic in_rdy,
  output logic first_ok,
  output logic out_bit,
  output logic out_vld
);
  localparam int KEPT = pce_pkg::count_ones(32'(PAT0)) + pce_pkg::count_ones(32'(PAT1));

  logic            accept, enc0, enc1, blk_done;
  logic [KEPT-1:0] blk_bits;

  pce_taps #(.CLEN(CLEN), .GEN0(GEN0), .GEN1(GEN1)) u_taps (
    .clk(clk), .srst(srst), .step(accept), .bit_i(in_bit),
    .enc0(enc0), .enc1(enc1)
  );

  pce_collect #(.PLEN(PLEN), .PAT0(PAT0), .PAT1(PAT1), .KEPT(KEPT)) u_coll (
    .clk(clk), .srst(srst), .en(en), .req(in_vld), .first(in_first),
    .enc0(enc0), .enc1(enc1), .accept(accept), .ready(in_rdy),
    .first_ok(first_ok), .blk_done(blk_done), .blk_bits(blk_bits)
  );

  pce_serial #(.KEPT(KEPT)) u_ser (
    .clk(clk), .srst(srst), .en(en), .load(blk_done), .blk(blk_bits),
    .out_bit(out_bit), .out_vld(out_vld)
  );

  // R9
  reset_state_chk: assert property (@(posedge clk)
    srst |=> (in_rdy && first_ok && !out_vld));
endmodule

// File: tb/sim_punct_conv_enc_serial.sv
module sim_punct_conv_enc_serial;
  localparam int K = 7;
  localparam logic [K-1:0] G0 = 7'b1011011;
  localparam logic [K-1:0] G1 = 7'b1111001;
  localparam int N = 3;
  localparam logic [N-1:0] P0 = 3'b101;
  localparam logic [N-1:0] P1 = 3'b011;
  localparam int M = 4;
  localparam int GAP = M - N;

  // {data bit, first flag}; restart at 7 (mid-block), first held at 12..14
  localparam logic [1:0] VEC [0:23] = '{
    2'b10, 2'b00, 2'b10, 2'b10, 2'b00, 2'b00, 2'b10, 2'b11,
    2'b00, 2'b10, 2'b10, 2'b10, 2'b01, 2'b11, 2'b01, 2'b00,
    2'b10, 2'b00, 2'b10, 2'b10, 2'b00, 2'b10, 2'b00, 2'b10};

  logic clk = 0, srst, en, in_vld, in_bit, in_first;
  logic in_rdy, first_ok, out_bit, out_vld;

  punct_conv_enc_serial #(.CLEN(K), .GEN0(G0), .GEN1(G1), .PLEN(N),
                          .PAT0(P0), .PAT1(P1)) u0 (
    .clk(clk), .srst(srst), .en(en), .in_vld(in_vld), .in_bit(in_bit),
    .in_first(in_first), .in_rdy(in_rdy), .first_ok(first_ok),
    .out_bit(out_bit), .out_vld(out_vld));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  logic got_b [0:1023];
  logic exp_b [0:1023];
  int got_n = 0, exp_n = 0;
  logic en_e = 0, rst_e = 1;

  logic [K-2:0] mhist;
  logic [N-1:0] mc0, mc1;
  logic [M-1:0] mhold;
  int  mpos;
  bit  mfp, blk_flag;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin en_e = en; rst_e = srst; end
  always @(negedge clk)
    if (out_vld && en_e && !rst_e && got_n < 1024) begin
      got_b[got_n] = out_bit;
      got_n++;
    end

  task automatic model_reset();
    mhist = '0; mc0 = '0; mc1 = '0; mhold = '0; mpos = 0; mfp = 0; blk_flag = 0;
  endtask

  task automatic model_take(bit b, bit f);
    logic [K-1:0] win;
    bit c0, c1;
    int slot, q;
    win = {mhist, b};
    c0 = 0; c1 = 0;
    for (int i = 0; i < K; i++) begin
      if (G0[i]) c0 ^= win[i];
      if (G1[i]) c1 ^= win[i];
    end
    mhist = win[K-2:0];
    slot = (f && !mfp) ? 0 : mpos;
    mfp = f;
    mc0[slot] = c0;
    mc1[slot] = c1;
    if (slot == N - 1) begin
      for (int i = 0; i < M; i++) begin exp_b[exp_n] = mhold[i]; exp_n++; end
      q = 0;
      for (int j = 0; j < N; j++) begin
        if (P0[j]) begin mhold[q] = mc0[j]; q++; end
        if (P1[j]) begin mhold[q] = mc1[j]; q++; end
      end
      mpos = 0;
      blk_flag = 1;
    end else mpos = slot + 1;
  endtask

  task automatic push(bit b, bit f, output int waits);
    bit rdy_now;
    waits = 0;
    in_vld = 1; in_first = f;
    forever begin
      rdy_now = in_rdy && en && !srst;
      in_bit = rdy_now ? b : ~b;
      @(posedge clk);
      @(negedge clk);
      if (rdy_now) begin model_take(b, f); break; end
      waits++;
    end
    in_vld = 0; in_first = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compare_seg(string tag);
    chk(got_n == exp_n, {tag, " count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got_b[i] == exp_b[i], tag, got_b[i], exp_b[i]);
    got_n = 0; exp_n = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int w;
    bit prev;
    srst = 1; en = 1; in_vld = 0; in_bit = 0; in_first = 0;
    model_reset();
    idle(3);
    srst = 0;
    idle(1);
    chk(in_rdy == 1, "R9 in_rdy after reset", in_rdy, 1);
    chk(out_vld == 0, "R9 out_vld after reset", out_vld, 0);
    chk(first_ok == 1, "R6 R9 first_ok after reset", first_ok, 1);

    // table walk
    for (int i = 0; i < 24; i++) begin
      prev = blk_flag;
      blk_flag = 0;
      if (mpos == 0 && in_rdy) chk(first_ok == 1, "R6 first_ok at boundary", first_ok, 1);
      push(VEC[i][1], VEC[i][0], w);
      if (prev) chk(w == GAP, "R3 stall length", w, GAP);
      if (i == 7 || i == 12) chk(first_ok == 0, "R6 first_ok after restart", first_ok, 0);
    end
    idle(12);
    for (int i = 0; i < M; i++) chk(got_b[i] == 0, "R4 first block zero", got_b[i], 0);
    compare_seg("R1 R2 R4 R5 R7 stream");

    // clock enable freeze
    begin
      logic ob, ov, ir;
      for (int i = 0; i < 6; i++) push(i[0] ^ i[1], 0, w);
      idle(1);
      en = 0; in_vld = 1; in_bit = 1;
      ob = out_bit; ov = out_vld; ir = in_rdy;
      for (int i = 0; i < 5; i++) begin
        idle(1);
        chk(out_bit == ob && out_vld == ov && in_rdy == ir, "R8 frozen",
            {out_bit, out_vld, in_rdy}, {ob, ov, ir});
      end
      en = 1; in_vld = 0;
      idle(12);
      compare_seg("R8 stream after freeze");
    end

    // synchronous clear
    for (int i = 0; i < 4; i++) push(1, 0, w);
    idle(8);
    compare_seg("R4 pre-clear stream");
    srst = 1; in_vld = 1; in_bit = 1;
    idle(1);
    chk(in_rdy == 1 && first_ok == 1, "R9 ready during clear", {in_rdy, first_ok}, 3);
    chk(out_vld == 0, "R9 out_vld during clear", out_vld, 0);
    idle(2);
    srst = 0; in_vld = 0;
    model_reset();
    got_n = 0; exp_n = 0;
    for (int i = 0; i < 6; i++) push(i[0], 0, w);
    idle(12);
    for (int i = 0; i < M; i++) chk(got_b[i] == 0, "R9 R4 zero block after clear", got_b[i], 0);
    compare_seg("R9 R1 stream after clear");

    summary();
    $finish;
  end
endmodule